// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block generates the word-address stream for a single channel of a two-dimensional DMA engine. A one-cycle start pulse captures a start word address, a line length, a line count field and a line stride, all counted in 32-bit words. The byte address is supplied already divided by four. The block then offers one address per beat on a valid/ready pair. A downstream bus master consumes the addresses; the sequencer itself moves no data and issues no transactions.

With a non-zero line length the block walks a frame of `cfg_ylen + 1` lines of `cfg_xlen` words each. Every new line begins `cfg_stride` words after the previous line's first word, so the stride is the line size plus any gap. A single completion pulse follows the last beat. A line length of zero selects circular mode instead. The address then climbs linearly through a region of `cfg_stride * (cfg_ylen + 1)` words and jumps back to the region start, forever. A pulse marks the end of the first half of the region and another marks the end of the second half, which suits ping-pong buffering. A synchronous stop drops the channel to idle at once in either mode.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `busy`, `addr_valid`, `frame_done` and `half_evt` are all 0.
- R2: A `start` pulse (with `stop` low) while idle captures the configuration. In the next cycle `busy` and `addr_valid` are 1 and `addr` equals `cfg_base`.
- R3: With `cfg_xlen` non-zero, the handshaken beats carry `base + y*stride + x` for y = 0..ylen and x = 0..xlen-1, row by row. That is exactly (ylen+1)*xlen beats.
- R4: While `addr_valid` is 1 and `addr_ready` is 0, `addr` and `addr_valid` hold their values.
- R5: In the cycle after the handshake of the last frame beat, `frame_done` is 1 for exactly one cycle, and `busy` and `addr_valid` are 0. A frame of one word (xlen 1, ylen 0) behaves the same.
- R6: With `cfg_xlen` equal to 0, beats carry `base + i`, where i counts 0..S-1 and then returns to 0 (S = stride*(ylen+1)). `busy` stays 1 and `frame_done` never rises. S must be even and at least 2.
- R7: In circular mode `half_evt` pulses for one cycle after the handshake of index S/2-1, with `half_sel` = 0 (first half). It pulses again after the handshake of index S-1, with `half_sel` = 1 (second half). No other cycle shows `half_evt`.
- R8: `stop` makes `busy`, `addr_valid`, `frame_done` and `half_evt` 0 in the next cycle, whatever `addr_ready` is. It also wins over a `start` given in the same cycle.
- R9: A `start` pulse while busy is ignored, and the running sequence continues unchanged.
- R10: Addresses are formed modulo 2^AW, so a region crossing the top of the address space wraps to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin (idle only) |
| stop | input | 1 | Synchronous abort to idle |
| cfg_base | input | AW | Start word address |
| cfg_xlen | input | LW | Words per line; 0 selects circular mode |
| cfg_ylen | input | LW | Line count minus one |
| cfg_stride | input | LW | Words from one line start to the next |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | AW | Current word address |
| busy | output | 1 | Sequence in progress |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| half_evt | output | 1 | One-cycle pulse at a circular half boundary |
| half_sel | output | 1 | Half that just finished (0 first, 1 second) |

## Verification
Random frame shapes are used: strides equal to the line length and strides with a gap, single-line and multi-line frames, and throttled ready against continuous ready. Together these separate errors in column wrap, row stepping and stall holding. Directed cases cover the one-word frame, a region crossing the address top, and a start pulse injected mid-frame. They also cover aborts mid-frame and mid-loop with ready high, and start and stop together while idle. Circular runs of more than two laps with different region sizes show whether both half pulses land on the right beats and whether the wrap returns to the base.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_FRAME = 2'd1,
        WALK_LOOP  = 2'd2
    } walk_mode_e;
endpackage

// File: rtl/dma2d_line_walker.sv
module dma2d_line_walker #(
    parameter int LW = 16,
    parameter int TW = 2 * LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [LW-1:0] xlen,
    input  logic [LW-1:0] ylen,
    input  logic [LW-1:0] stride,
    output logic [TW-1:0] offset,
    output logic          last_beat
);
    typedef struct packed {
        logic [LW-1:0] col;
        logic [LW-1:0] row;
        logic [TW-1:0] line;
    } walk_state_t;

    walk_state_t s_d, s_q;
    logic col_end, row_end;

    always_comb begin
        col_end = (s_q.col == xlen - LW'(1));
        row_end = (s_q.row == ylen);
        s_d     = s_q;
        if (load) begin
            s_d = '0;
        end else if (step) begin
            if (col_end) begin
                s_d.col = '0;
                if (!row_end) begin
                    s_d.row  = s_q.row + LW'(1);
                    s_d.line = s_q.line + TW'(stride);
                end
            end else begin
                s_d.col = s_q.col + LW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign offset    = s_q.line + TW'(s_q.col);
    assign last_beat = col_end && row_end;

    // R3: a beat is never taken outside the configured column range
    assert_col_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (s_q.col < xlen));
    // R3: rows never run past the configured count
    assert_row_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (s_q.row <= ylen));
endmodule

// File: rtl/dma2d_ring_walker.sv
module dma2d_ring_walker #(
    parameter int TW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic          step,
    input  logic [TW-1:0] span,
    output logic [TW-1:0] offset,
    output logic          end_first,
    output logic          end_second
);
    typedef struct packed {
        logic [TW-1:0] idx;
    } ring_state_t;

    ring_state_t s_d, s_q;

    always_comb begin
        end_first  = (s_q.idx == (span >> 1) - TW'(1));
        end_second = (s_q.idx == span - TW'(1));
        s_d        = s_q;
        if (load) begin
            s_d.idx = '0;
        end else if (step) begin
            s_d.idx = end_second ? '0 : s_q.idx + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign offset = s_q.idx;

    // R6: the index stays inside the region for any legal region size
    assert_idx_in_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && span >= TW'(2)) |-> (s_q.idx < span));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 30,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_xlen,
    input  logic [LW-1:0] cfg_ylen,
    input  logic [LW-1:0] cfg_stride,
    output logic          addr_valid,
    input  logic          addr_ready,
    output logic [AW-1:0] addr,
    output logic          busy,
    output logic          frame_done,
    output logic          half_evt,
    output logic          half_sel
);
    localparam int TW = 2 * LW + 1;

    typedef struct packed {
        walk_mode_e    mode;
        logic [AW-1:0] base;
        logic [LW-1:0] xlen;
        logic [LW-1:0] ylen;
        logic [LW-1:0] stride;
        logic [TW-1:0] span;
        logic          done;
        logic          half;
        logic          sel;
    } ctl_state_t;

    ctl_state_t r_d, r_q;

    logic          hs, load_w, frame_step, loop_step;
    logic [TW-1:0] line_off, ring_off;
    logic          line_last, ring_end_a, ring_end_b;

    assign hs         = addr_valid && addr_ready;
    assign load_w     = start && !stop && (r_q.mode == WALK_IDLE);
    assign frame_step = hs && !stop && (r_q.mode == WALK_FRAME);
    assign loop_step  = hs && !stop && (r_q.mode == WALK_LOOP);

    dma2d_line_walker #(.LW(LW), .TW(TW)) i_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .step      (frame_step),
        .xlen      (r_q.xlen),
        .ylen      (r_q.ylen),
        .stride    (r_q.stride),
        .offset    (line_off),
        .last_beat (line_last)
    );

    dma2d_ring_walker #(.TW(TW)) i_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_w),
        .run        (r_q.mode == WALK_LOOP),
        .step       (loop_step),
        .span       (r_q.span),
        .offset     (ring_off),
        .end_first  (ring_end_a),
        .end_second (ring_end_b)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.half = 1'b0;
        if (stop) begin
            r_d.mode = WALK_IDLE;
        end else if (load_w) begin
            r_d.base   = cfg_base;
            r_d.xlen   = cfg_xlen;
            r_d.ylen   = cfg_ylen;
            r_d.stride = cfg_stride;
            r_d.span   = TW'(cfg_stride) * (TW'(cfg_ylen) + TW'(1));
            r_d.mode   = (cfg_xlen == '0) ? WALK_LOOP : WALK_FRAME;
        end else if (frame_step && line_last) begin
            r_d.mode = WALK_IDLE;
            r_d.done = 1'b1;
        end else if (loop_step) begin
            if (ring_end_a) begin
                r_d.half = 1'b1;
                r_d.sel  = 1'b0;
            end
            if (ring_end_b) begin
                r_d.half = 1'b1;
                r_d.sel  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= WALK_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_valid = (r_q.mode != WALK_IDLE);
    assign busy       = addr_valid;
    assign addr       = r_q.base + ((r_q.mode == WALK_LOOP) ? AW'(ring_off) : AW'(line_off));
    assign frame_done = r_q.done;
    assign half_evt   = r_q.half;
    assign half_sel   = r_q.sel;

    // R4: a stalled address is held
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready && !stop && !load_w) |=> (addr_valid && $stable(addr)));
    // R5: completion is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R5: completion is seen with the channel already idle
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);
    // R6: circular mode never completes
    assert_loop_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mode == WALK_LOOP) |=> !frame_done);
    // R7: a half pulse always follows a handshake
    assert_half_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |-> $past(addr_valid && addr_ready));
    // R8: stop forces idle with no event
    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !frame_done && !half_evt));
    // R9: a start while busy leaves a stalled address alone
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !stop && !addr_ready) |=> (busy && $stable(addr)));
endmodule

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, stop = 1'b0, addr_ready = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [LW-1:0] cfg_xlen = '0, cfg_ylen = '0, cfg_stride = '0;
    logic          addr_valid, busy, frame_done, half_evt, half_sel;
    logic [AW-1:0] addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma2d_addr_gen #(.AW(AW), .LW(LW)) i_dma2d_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_base(cfg_base), .cfg_xlen(cfg_xlen), .cfg_ylen(cfg_ylen),
        .cfg_stride(cfg_stride), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr(addr), .busy(busy), .frame_done(frame_done),
        .half_evt(half_evt), .half_sel(half_sel)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] frame_addr(logic [AW-1:0] b, int x, int y, int st);
        return AW'(longint'(b) + longint'(y) * st + x);
    endfunction

    function automatic logic [AW-1:0] ring_addr(logic [AW-1:0] b, int i);
        return AW'(longint'(b) + i);
    endfunction

    task automatic kick(logic [AW-1:0] b, int x, int y, int st);
        @(negedge clk);
        cfg_base = b; cfg_xlen = LW'(x); cfg_ylen = LW'(y); cfg_stride = LW'(st);
        addr_ready = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after start", busy, 1);
        chk("R2", "first addr", addr, b);
    endtask

    task automatic run_frame(logic [AW-1:0] b, int x, int y, int st, int pct,
                             int abort_at, int poke_at);
        int xi = 0, yi = 0, beats = 0;
        bit fin = 0, poked = 0, stalled = 0;
        kick(b, x, y, st);
        while (!fin) begin
            chk(poked ? "R9" : "R3", "valid", addr_valid, 1);
            chk(stalled ? "R4" : (poked ? "R9" : "R3"), "addr", addr, frame_addr(b, xi, yi, st));
            chk("R5", "no early done", frame_done, 0);
            if (beats == abort_at) begin
                stop = 1'b1; addr_ready = 1'b1;
                @(negedge clk);
                stop = 1'b0; addr_ready = 1'b0;
                chk("R8", "busy after stop", busy, 0);
                chk("R8", "valid after stop", addr_valid, 0);
                chk("R8", "no done on stop", frame_done, 0);
                return;
            end
            if (beats == poke_at && !poked) begin
                poked = 1;
                start = 1'b1;
                cfg_base = ~b; cfg_xlen = LW'(x + 3); cfg_ylen = LW'(y + 2); cfg_stride = LW'(st + 5);
            end
            addr_ready = (($urandom % 100) < pct);
            stalled = !addr_ready;
            @(negedge clk);
            start = 1'b0;
            if (!stalled) begin
                beats++;
                if (xi == x - 1) begin
                    xi = 0;
                    if (yi == y) begin
                        fin = 1;
                        chk("R5", "done pulse", frame_done, 1);
                        chk("R5", "busy at done", busy, 0);
                        chk("R5", "valid at done", addr_valid, 0);
                    end else yi++;
                end else xi++;
            end
        end
        chk("R3", "beat count", beats, x * (y + 1));
        addr_ready = 1'b0;
        @(negedge clk);
        chk("R5", "done is one cycle", frame_done, 0);
        chk("R5", "stays idle", busy, 0);
    endtask

    task automatic run_loop(logic [AW-1:0] b, int y, int st, int pct, int total);
        int span = st * (y + 1);
        int half = span / 2;
        int idx = 0, beats = 0;
        bit exp_half = 0, exp_sel = 0;
        kick(b, 0, y, st);
        while (1) begin
            chk("R6", "busy in loop", busy, 1);
            chk("R6", "loop addr", addr, ring_addr(b, idx));
            chk("R6", "no done in loop", frame_done, 0);
            chk("R7", "half event", half_evt, exp_half);
            if (exp_half) chk("R7", "half select", half_sel, exp_sel);
            if (beats >= total) break;
            addr_ready = (($urandom % 100) < pct);
            @(negedge clk);
            exp_half = 0;
            if (addr_ready) begin
                beats++;
                if (idx == half - 1) begin exp_half = 1; exp_sel = 0; end
                if (idx == span - 1) begin exp_half = 1; exp_sel = 1; idx = 0; end
                else idx++;
            end
        end
        stop = 1'b1; addr_ready = 1'b1;
        @(negedge clk);
        stop = 1'b0; addr_ready = 1'b0;
        chk("R8", "busy after loop stop", busy, 0);
        chk("R8", "no half after stop", half_evt, 0);
        chk("R8", "no done after stop", frame_done, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "valid", addr_valid, 0);
        chk("R1", "done", frame_done, 0);
        chk("R1", "half", half_evt, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after release", busy, 0);

        // R8: start and stop together while idle
        cfg_base = 30'h100; cfg_xlen = 16'd2; cfg_ylen = 16'd0; cfg_stride = 16'd2;
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk("R8", "stop beats start", busy, 0);

        // R5: single-word frame, continuous ready
        run_frame(30'h1234, 1, 0, 1, 100, -1, -1);
        // R3: packed lines and gapped lines
        run_frame(30'h2000, 4, 2, 4, 100, -1, -1);
        run_frame(30'h3000, 3, 3, 7, 50, -1, -1);
        // R10: region crossing the address top
        run_frame(30'h3FFF_FFFD, 4, 1, 8, 70, -1, -1);
        // R9: start injected mid-frame
        run_frame(30'h4000, 3, 2, 5, 60, -1, 4);
        // R8: abort mid-frame
        run_frame(30'h5000, 5, 3, 6, 80, 7, -1);

        for (int k = 0; k < 12; k++) begin
            int x = 1 + ($urandom % 6);
            int y = $urandom % 5;
            int st = x + ($urandom % 4);
            run_frame(AW'($urandom), x, y, st, 30 + ($urandom % 71), -1, -1);
        end

        // R6/R7: circular runs, minimum region and larger ones
        run_loop(30'h6000, 0, 2, 100, 7);
        run_loop(30'h7000, 2, 4, 60, 30);
        run_loop(30'h3FFF_FFFA, 1, 6, 75, 29);
        for (int k = 0; k < 4; k++) begin
            int y = $urandom % 4;
            int st = 2 * (1 + ($urandom % 3));
            run_loop(AW'($urandom), y, st, 40 + ($urandom % 61), 2 * st * (y + 1) + 3);
        end

        // restart after loop abort
        run_frame(30'h8000, 2, 1, 3, 100, -1, -1);

        summary();
        $finish;
    end
endmodule